// File: doc/BRIEF.md
# Packed SIMD Add/Subtract/Min-Max Unit

This block is a one-stage packed integer datapath for 32-bit words. Each operation splits both operands into lanes and applies the same function to every lane: add, subtract, halving add, halving subtract, minimum, maximum, or one of three comparisons. The opcode does not set the lane layout. The layout comes from the register indices that name the operands. Each index range maps to a fixed lane width and signedness, so the same opcode acts on bytes, half-words or a whole word depending on where the operands live.

A 2-bit mode field chooses between wraparound and clamped arithmetic. Comparisons write an all-ones or all-zeros pattern into each result lane and also drive a per-lane flag vector. Operand indices that name the zero register or the predicate register are rejected. So are operand sets that mix index ranges. In both cases the unit reports the error and keeps its previous result.

Operations enter through a valid/ready input port and leave through a single output register with a valid/ready output port. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output register and the error flags hold, and no new operation is accepted.

Top module: `simd_addsub_unit`

## Requirements
- R1: The lane layout follows the index range shared by `in_rd`, `in_rs1` and `in_rs2`:
  - 2..7 give four signed 8-bit lanes.
  - 8..15 give four unsigned 8-bit lanes.
  - 16..23 give two signed 16-bit lanes.
  - 24..29 give two unsigned 16-bit lanes.
  - 30..31 give one signed 32-bit lane.
  - Lane i occupies bits [i*W +: W].
- R2: `out_err_illegal` is set and `out_res`/`out_mask` keep their previous values when any of the following holds:
  - any of the three indices is 0 or 1;
  - `in_op` is above 8;
  - `in_mode[1]` is 1.
- R3: A legal operation whose three indices do not all fall in the same range sets `out_err_bank` and leaves `out_res`/`out_mask` unchanged. The two error flags are never set together.
- R4: With mode 00, op 0 (add) and op 1 (subtract) give the per-lane result modulo 2^W.
- R5: With mode 01, add and subtract clamp to the lane's range. Signed lanes clamp to [-2^(W-1), 2^(W-1)-1]. Unsigned lanes clamp to [0, 2^W-1].
- R6: Op 2 returns the low W bits of floor((a+b)/2) per lane, and op 3 returns the low W bits of floor((a-b)/2) per lane. Both are computed exactly, without intermediate overflow, with operands interpreted per the lane's signedness.
- R7: Op 4 returns the per-lane minimum and op 5 the per-lane maximum, compared signed or unsigned according to the range.
- R8: Comparison ops work as follows:
  - Op 6 tests a==b, op 7 tests a<=b, and op 8 tests a<b, the last produced as the inverse of a>=b.
  - Each result lane is all ones when the test is true and zero otherwise.
  - `out_mask` bit i carries lane i's outcome; bits above the lane count are 0.
  - Any non-comparison op writes `out_mask` as 0.
- R9: An accepted operation appears on the outputs after the next rising edge with `out_valid` high. Without back-pressure, `out_valid` stays high for exactly one cycle per operation. While `out_valid` is high and `out_ready` is low, all outputs hold and `in_ready` is low.
- R10: Mode 01 has no effect on ops 2 through 8.
- R11: After reset `out_valid`, `out_res`, `out_mask` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 4 | Operation code 0..8 |
| in_mode | input | 2 | 00 wraparound, 01 saturating |
| in_rd | input | 5 | Destination register index |
| in_rs1 | input | 5 | Index of operand A |
| in_rs2 | input | 5 | Index of operand B |
| in_a | input | 32 | Operand A packed word |
| in_b | input | 32 | Operand B packed word |
| out_valid | output | 1 | Result register holds an operation |
| out_ready | input | 1 | Downstream takes the result |
| out_res | output | 32 | Packed result word |
| out_mask | output | 4 | Per-lane comparison flags |
| out_err_illegal | output | 1 | Illegal operand index, opcode or mode |
| out_err_bank | output | 1 | Operand indices span different ranges |

## Verification
The bound checker watches the handshake on every cycle: an accepted operation is followed by `out_valid`, a stalled output holds steady, and `out_valid` drops once the output is drained. It also checks on every cycle that an index of 0 or 1 raises the illegal flag without disturbing the result, that the two error flags never coincide, and that a non-comparison op cannot raise mask bits. The arithmetic itself can only be shown by the bench's scenarios, which compare results against an independent lane model under random and directed operands. These include the saturation edges, halving overflow, signed versus unsigned ordering, the mismatched-range case and a back-pressure sequence.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [2:0] {
    BK_ZERO = 3'd0,
    BK_MASK = 3'd1,
    BK_S8   = 3'd2,
    BK_U8   = 3'd3,
    BK_S16  = 3'd4,
    BK_U16  = 3'd5,
    BK_S32  = 3'd6
  } bank_e;

  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OPC_W-1:0] OP_SUB  = 4'd1;
  localparam logic [OPC_W-1:0] OP_HADD = 4'd2;
  localparam logic [OPC_W-1:0] OP_HSUB = 4'd3;
  localparam logic [OPC_W-1:0] OP_MIN  = 4'd4;
  localparam logic [OPC_W-1:0] OP_MAX  = 4'd5;
  localparam logic [OPC_W-1:0] OP_CEQ  = 4'd6;
  localparam logic [OPC_W-1:0] OP_CLE  = 4'd7;
  localparam logic [OPC_W-1:0] OP_CLT  = 4'd8;
  localparam logic [OPC_W-1:0] OP_LAST = OP_CLT;

endpackage

// File: rtl/simd_bank_decode.sv
module simd_bank_decode
  import simd_alu_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int S8_LO  = 2,
  parameter int U8_LO  = 8,
  parameter int S16_LO = 16,
  parameter int U16_LO = 24,
  parameter int S32_LO = 30
) (
  input  logic [IDX_W-1:0] idx_i,
  output bank_e            bank_o
);

  // Ranges are contiguous and ascending; each lower bound starts a new bank.
  always_comb begin
    if (idx_i == IDX_W'(0))               bank_o = BK_ZERO;
    else if (idx_i < IDX_W'(S8_LO))       bank_o = BK_MASK;
    else if (idx_i < IDX_W'(U8_LO))       bank_o = BK_S8;
    else if (idx_i < IDX_W'(S16_LO))      bank_o = BK_U8;
    else if (idx_i < IDX_W'(U16_LO))      bank_o = BK_S16;
    else if (idx_i < IDX_W'(S32_LO))      bank_o = BK_U16;
    else                                  bank_o = BK_S32;
  end

endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             sgn_i,
  input  logic             sat_i,
  input  logic [OPC_W-1:0] op_i,
  output logic [W-1:0]     r_o,
  output logic             flag_o
);

  logic [W:0]   ax, bx, sum, dif;
  logic [W-1:0] s_max, s_min, add_r, sub_r;
  logic         gt, ge, eq;

  always_comb begin
    // One extra bit: sign- or zero-extended so sums and differences are exact.
    ax    = {sgn_i & a_i[W-1], a_i};
    bx    = {sgn_i & b_i[W-1], b_i};
    sum   = ax + bx;
    dif   = ax - bx;
    s_max = {1'b0, {(W-1){1'b1}}};
    s_min = {1'b1, {(W-1){1'b0}}};

    add_r = sum[W-1:0];
    sub_r = dif[W-1:0];
    if (sat_i) begin
      if (sgn_i) begin
        if (sum[W] != sum[W-1]) add_r = sum[W] ? s_min : s_max;
        if (dif[W] != dif[W-1]) sub_r = dif[W] ? s_min : s_max;
      end else begin
        if (sum[W]) add_r = '1;
        if (dif[W]) sub_r = '0;
      end
    end

    gt = $signed(ax) >  $signed(bx);
    ge = $signed(ax) >= $signed(bx);
    eq = (a_i == b_i);

    flag_o = 1'b0;
    unique case (op_i)
      OP_ADD:  r_o = add_r;
      OP_SUB:  r_o = sub_r;
      OP_HADD: r_o = sum[W:1];
      OP_HSUB: r_o = dif[W:1];
      OP_MIN:  r_o = ge ? b_i : a_i;
      OP_MAX:  r_o = gt ? a_i : b_i;
      OP_CEQ:  begin flag_o = eq;  r_o = {W{eq}};  end
      OP_CLE:  begin flag_o = !gt; r_o = {W{!gt}}; end
      OP_CLT:  begin flag_o = !ge; r_o = {W{!ge}}; end
      default: r_o = '0;
    endcase
  end

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  bank_e               bank_i,
  input  logic [OPC_W-1:0]    op_i,
  input  logic                sat_i,
  output logic [DATA_W-1:0]   res_o,
  output logic [DATA_W/8-1:0] mask_o
);

  localparam int N8     = DATA_W / 8;
  localparam int N16    = DATA_W / 16;
  localparam int MASK_W = N8;

  logic [DATA_W-1:0] r8, r16, rw;
  logic [N8-1:0]     f8;
  logic [N16-1:0]    f16;
  logic              fw;
  logic              is_cmp;

  genvar g;
  generate
    for (g = 0; g < N8; g++) begin : g_b8
      simd_lane #(.W(8)) u_lane (
        .a_i(a_i[8*g +: 8]), .b_i(b_i[8*g +: 8]),
        .sgn_i(bank_i == BK_S8), .sat_i(sat_i), .op_i(op_i),
        .r_o(r8[8*g +: 8]), .flag_o(f8[g])
      );
    end
    for (g = 0; g < N16; g++) begin : g_b16
      simd_lane #(.W(16)) u_lane (
        .a_i(a_i[16*g +: 16]), .b_i(b_i[16*g +: 16]),
        .sgn_i(bank_i == BK_S16), .sat_i(sat_i), .op_i(op_i),
        .r_o(r16[16*g +: 16]), .flag_o(f16[g])
      );
    end
  endgenerate

  simd_lane #(.W(DATA_W)) u_word (
    .a_i(a_i), .b_i(b_i), .sgn_i(1'b1), .sat_i(sat_i), .op_i(op_i),
    .r_o(rw), .flag_o(fw)
  );

  always_comb begin
    is_cmp = (op_i == OP_CEQ) || (op_i == OP_CLE) || (op_i == OP_CLT);
    unique case (bank_i)
      BK_S8, BK_U8: begin
        res_o  = r8;
        mask_o = f8;
      end
      BK_S16, BK_U16: begin
        res_o  = r16;
        mask_o = MASK_W'(f16);
      end
      default: begin
        res_o  = rw;
        mask_o = MASK_W'(fw);
      end
    endcase
    if (!is_cmp) mask_o = '0;
  end

endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [3:0]          in_op,
  input  logic [1:0]          in_mode,
  input  logic [IDX_W-1:0]    in_rd,
  input  logic [IDX_W-1:0]    in_rs1,
  input  logic [IDX_W-1:0]    in_rs2,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_res,
  output logic [DATA_W/8-1:0] out_mask,
  output logic                out_err_illegal,
  output logic                out_err_bank
);

  localparam int MASK_W = DATA_W / 8;
  localparam int N_IDX  = 3;

  logic [IDX_W-1:0]  idx [N_IDX];
  bank_e             bk  [N_IDX];
  logic              bad_idx, bad_op, illegal, mismatch, accept;
  logic [DATA_W-1:0] dp_res;
  logic [MASK_W-1:0] dp_mask;

  assign idx[0] = in_rs1;
  assign idx[1] = in_rs2;
  assign idx[2] = in_rd;

  genvar g;
  generate
    for (g = 0; g < N_IDX; g++) begin : g_dec
      simd_bank_decode #(.IDX_W(IDX_W)) u_dec (.idx_i(idx[g]), .bank_o(bk[g]));
    end
  endgenerate

  always_comb begin
    bad_idx = 1'b0;
    for (int k = 0; k < N_IDX; k++)
      if (bk[k] == BK_ZERO || bk[k] == BK_MASK) bad_idx = 1'b1;
    bad_op   = (in_op > OP_LAST) || in_mode[1];
    illegal  = bad_idx || bad_op;
    mismatch = !illegal && ((bk[0] != bk[1]) || (bk[0] != bk[2]));
  end

  simd_datapath #(.DATA_W(DATA_W)) u_dp (
    .a_i(in_a), .b_i(in_b), .bank_i(bk[0]), .op_i(in_op),
    .sat_i(in_mode == 2'b01), .res_o(dp_res), .mask_o(dp_mask)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_res         <= '0;
      out_mask        <= '0;
      out_err_illegal <= 1'b0;
      out_err_bank    <= 1'b0;
    end else if (accept) begin
      out_valid       <= 1'b1;
      out_err_illegal <= illegal;
      out_err_bank    <= mismatch;
      if (!illegal && !mismatch) begin
        out_res  <= dp_res;
        out_mask <= dp_mask;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [3:0]          in_op,
  input logic [IDX_W-1:0]    in_rd,
  input logic [IDX_W-1:0]    in_rs1,
  input logic [IDX_W-1:0]    in_rs2,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_W-1:0]   out_res,
  input logic [DATA_W/8-1:0] out_mask,
  input logic                out_err_illegal,
  input logic                out_err_bank
);

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_mask)
      && $stable(out_err_illegal) && $stable(out_err_bank));

  p_stall_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) && (out_ready || !out_valid) |=> !out_valid);

  p_zero_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_rd < 2 || in_rs1 < 2 || in_rs2 < 2)
      |=> out_err_illegal && $stable(out_res) && $stable(out_mask));

  p_err_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_err_illegal && out_err_bank));

  p_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op < 4'd6 |=> out_mask == '0 || $stable(out_mask));

endmodule

bind simd_addsub_unit simd_addsub_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/simd_addsub_unit_test.sv
`timescale 1ns/1ps
module simd_addsub_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_mode = '0;
  logic [4:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_res;
  logic [3:0]  out_mask;
  logic        out_err_illegal, out_err_bank;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_res  = '0;
  logic [3:0]  exp_mask = '0;

  always #2.5 clk = ~clk;

  simd_addsub_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_mode(in_mode), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_mask(out_mask),
    .out_err_illegal(out_err_illegal), .out_err_bank(out_err_bank)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // 0 zero, 1 mask, 2 s8, 3 u8, 4 s16, 5 u16, 6 s32
  function automatic int bank_of(input int idx);
    if (idx == 0) return 0;
    if (idx == 1) return 1;
    if (idx <= 7) return 2;
    if (idx <= 15) return 3;
    if (idx <= 23) return 4;
    if (idx <= 29) return 5;
    return 6;
  endfunction

  function automatic int pick_idx(input int bank);
    case (bank)
      2: return 2 + int'($urandom % 6);
      3: return 8 + int'($urandom % 8);
      4: return 16 + int'($urandom % 8);
      5: return 24 + int'($urandom % 6);
      default: return 30 + int'($urandom % 2);
    endcase
  endfunction

  function automatic longint lane_val(input logic [31:0] x, input int i, input int w, input bit sgn);
    longint m = (longint'(1) << w) - 1;
    longint v = (longint'(x) >> (i * w)) & m;
    if (sgn && v[w-1]) v = v - (longint'(1) << w);
    return v;
  endfunction

  function automatic longint lane_op(input int op, input bit sat, input bit sgn, input int w,
                                     input longint av, input longint bv, output bit flg);
    longint lo = sgn ? -(longint'(1) << (w - 1)) : 0;
    longint hi = sgn ? (longint'(1) << (w - 1)) - 1 : (longint'(1) << w) - 1;
    longint t;
    flg = 1'b0;
    case (op)
      0: begin t = av + bv; if (sat) t = (t > hi) ? hi : (t < lo) ? lo : t; end
      1: begin t = av - bv; if (sat) t = (t > hi) ? hi : (t < lo) ? lo : t; end
      2: t = (av + bv) >>> 1;
      3: t = (av - bv) >>> 1;
      4: t = (av < bv) ? av : bv;
      5: t = (av > bv) ? av : bv;
      6: begin flg = (av == bv); t = flg ? -1 : 0; end
      7: begin flg = (av <= bv); t = flg ? -1 : 0; end
      default: begin flg = (av < bv); t = flg ? -1 : 0; end
    endcase
    return t;
  endfunction

  task automatic model(input int op, input int mode, input int rd, input int r1, input int r2,
                       input logic [31:0] a, input logic [31:0] b,
                       output bit eill, output bit ebank);
    int bd = bank_of(rd), b1 = bank_of(r1), b2 = bank_of(r2);
    int w, n;
    bit sgn, flg;
    longint acc = 0, t;
    logic [3:0] m = '0;
    eill  = (bd < 2) || (b1 < 2) || (b2 < 2) || (op > 8) || (mode >= 2);
    ebank = !eill && ((bd != b1) || (b1 != b2));
    if (eill || ebank) return;
    w   = (b1 <= 3) ? 8 : (b1 <= 5) ? 16 : 32;
    sgn = (b1 == 2) || (b1 == 4) || (b1 == 6);
    n   = 32 / w;
    for (int i = 0; i < n; i++) begin
      t = lane_op(op, mode == 1, sgn, w, lane_val(a, i, w, sgn), lane_val(b, i, w, sgn), flg);
      acc = acc | ((t & ((longint'(1) << w) - 1)) << (i * w));
      if (op >= 6) m[i] = flg;
    end
    exp_res  = acc[31:0];
    exp_mask = m;
  endtask

  task automatic do_op(input string tag, input int op, input int mode, input int rd,
                       input int r1, input int r2, input logic [31:0] a, input logic [31:0] b);
    bit eill, ebank;
    @(negedge clk);
    in_op = op[3:0]; in_mode = mode[1:0]; in_rd = rd[4:0]; in_rs1 = r1[4:0]; in_rs2 = r2[4:0];
    in_a = a; in_b = b; in_valid = 1'b1;
    model(op, mode, rd, r1, r2, a, b, eill, ebank);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "out_valid", out_valid, 1);
    check(tag, "result", out_res, exp_res);
    check(tag, "mask", out_mask, exp_mask);
    check("R2", "err_illegal", out_err_illegal, eill);
    check("R3", "err_bank", out_err_bank, ebank);
  endtask

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] keep;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check("R11", "out_valid", out_valid, 0);
    check("R11", "out_res", out_res, 0);
    check("R11", "errs", {out_err_illegal, out_err_bank}, 0);
    rst_n = 1'b1;

    // R1/R4: same word, three layouts
    do_op("R4", 0, 0, 3, 4, 5, 32'h80FF_7F01, 32'h8001_0101);
    do_op("R4", 0, 0, 20, 17, 23, 32'h80FF_7F01, 32'h8001_0101);
    do_op("R1", 1, 0, 31, 30, 31, 32'h0000_0000, 32'h0000_0001);
    // R5 saturation corners
    do_op("R5", 0, 1, 2, 3, 4, 32'h7F80_7F00, 32'h01FF_0000);
    do_op("R5", 1, 1, 2, 3, 4, 32'h807F_0000, 32'h01FF_0000);
    do_op("R5", 0, 1, 9, 10, 11, 32'hFF00_FE01, 32'h0100_0101);
    do_op("R5", 1, 1, 24, 25, 26, 32'h0000_0005, 32'h0001_0006);
    do_op("R5", 0, 1, 30, 31, 30, 32'h7FFF_FFFF, 32'h0000_0001);
    // R6 halving without overflow
    do_op("R6", 2, 0, 16, 17, 18, 32'h7FFF_8000, 32'h7FFF_8000);
    do_op("R6", 2, 0, 24, 25, 26, 32'hFFFF_0001, 32'hFFFF_0000);
    do_op("R6", 3, 0, 8, 9, 10, 32'h0000_00FF, 32'h0200_0001);
    // R7 min/max signed vs unsigned
    do_op("R7", 4, 0, 2, 3, 4, 32'h80FF_017F, 32'h7F01_0280);
    do_op("R7", 4, 0, 8, 9, 10, 32'h80FF_017F, 32'h7F01_0280);
    do_op("R7", 5, 0, 30, 30, 31, 32'h8000_0000, 32'h0000_0001);
    // R8 comparisons
    do_op("R8", 6, 0, 5, 6, 7, 32'h1122_3344, 32'h1122_0044);
    do_op("R8", 7, 0, 20, 21, 22, 32'hFFFF_0003, 32'h0001_0003);
    do_op("R8", 8, 0, 26, 27, 28, 32'hFFFF_0003, 32'h0001_0003);
    do_op("R8", 0, 0, 12, 13, 14, 32'h1, 32'h2);
    // R10: mode 01 ignored on min and halving
    do_op("R10", 4, 1, 2, 3, 4, 32'h80FF_017F, 32'h7F01_0280);
    do_op("R10", 2, 1, 16, 17, 18, 32'h7FFF_8000, 32'h7FFF_8000);
    // R2 / R3 errors keep result
    keep = exp_res;
    do_op("R2", 0, 0, 0, 3, 4, 32'h1234, 32'h1);
    check("R2", "held result", out_res, keep);
    do_op("R2", 1, 0, 3, 1, 4, 32'h1234, 32'h1);
    do_op("R2", 9, 0, 3, 4, 5, 32'h1234, 32'h1);
    do_op("R2", 0, 2, 3, 4, 5, 32'h1234, 32'h1);
    do_op("R3", 0, 0, 3, 4, 9, 32'h1234, 32'h1);
    check("R3", "held result", out_res, keep);
    do_op("R3", 0, 0, 17, 16, 24, 32'h1234, 32'h1);
    // R9: single-cycle pulse
    @(negedge clk);
    check("R9", "pulse ends", out_valid, 0);

    // R9 back-pressure
    out_ready = 1'b0;
    in_op = 4'd0; in_mode = 2'd0; in_rd = 5'd3; in_rs1 = 5'd4; in_rs2 = 5'd5;
    in_a = 32'h0102_0304; in_b = 32'h0101_0101; in_valid = 1'b1;
    @(negedge clk);
    check("R9", "valid under stall", out_valid, 1);
    check("R9", "in_ready under stall", in_ready, 0);
    in_a = 32'h1000_0000; in_b = 32'h0100_0000;
    @(negedge clk);
    check("R9", "held A", out_res, 32'h0203_0405);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "B after drain", out_res, 32'h1100_0000);
    check("R9", "valid for B", out_valid, 1);
    @(negedge clk);
    check("R9", "drained", out_valid, 0);
    exp_res = 32'h1100_0000; exp_mask = '0;

    // random mix
    for (int it = 0; it < 400; it++) begin
      int bk = 2 + int'($urandom % 5);
      int op = int'($urandom % 10);
      int md = (($urandom % 8) == 0) ? int'($urandom % 4) : int'($urandom % 2);
      int rd = pick_idx(bk), r1 = pick_idx(bk), r2 = pick_idx(bk);
      string tg;
      if (($urandom % 10) == 0) r2 = int'($urandom % 32);
      if (($urandom % 12) == 0) rd = int'($urandom % 32);
      tg = (op <= 1) ? ((md == 1) ? "R5" : "R4") : (op <= 3) ? "R6" : (op <= 5) ? "R7" : "R8";
      do_op(tg, op, md, rd, r1, r2, $urandom, ($urandom % 4 == 0) ? 32'h0 : $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule